// File: doc/BRIEF.md
# Shared-Subexpression Transposed FIR Filter

This block is a fixed-coefficient, four-tap FIR filter built in transposed form. Each accepted input sample goes to every tap in the same clock cycle. The filter has no hardware multipliers. Each coefficient is made from right shifts and additions on three buses that all taps share:

- the raw sample,
- the sample minus a quarter of itself (digit pattern 1 0 -1),
- the sample plus a quarter of itself (digit pattern 1 0 1).

Each tap adds up to two signed, right-shifted bus selections to the partial sum that arrives from the next delay element. The result is written into its own delay element.

The signal path carries four extra fractional bits, so every coefficient product is exact. Only the final output is rounded, to an 18-bit integer. An upstream stage presents a sample together with a valid strobe. One clock after each accepted sample, the filter presents the filtered sample with its own valid strobe. The default coefficients are 0.75, -0.3125, 0.625 and 1.25, applied to the current sample and to the three older samples in that order. Each default coefficient uses a single shared bus term:

| Coefficient | Bus term |
|---|---|
| 0.75 | low bus, no shift |
| -0.3125 | high bus, shifted right by 2, negated |
| 0.625 | high bus, shifted right by 1 |
| 1.25 | high bus, no shift |

Top module: `fir_csd_share`

## Requirements
- R1: After reset, outValid is 0, outData is 0 and all delay elements are 0. The first output after reset therefore depends only on the first accepted sample.
- R2: outValid is 1 in exactly the cycles that follow a clock edge at which inValid was 1.
- R3: An impulse of amplitude A, followed by zeros, produces the outputs round(0.75A), round(-0.3125A), round(0.625A), round(1.25A), then zeros.
- R4: For accepted samples x0 (newest) to x3 (oldest), outData = floor((12*x0 - 5*x1 + 10*x2 + 20*x3 + 8) / 16), read as an 18-bit two's-complement value. inData is a 16-bit two's-complement value.
- R5: A cycle with inValid at 0 is ignored. The delay chain keeps its contents, outData keeps its last value, and the data on inData in that cycle never affects any output.
- R6: Rounding adds one half LSB and then drops the four fractional bits, so exact halves round toward plus infinity. An amplitude of +1 gives 1, 0, 1, 1 and an amplitude of -1 gives -1, 0, -1, -1.
- R7: A step of amplitude A settles at floor((37*A + 8) / 16). For the full-scale inputs -32768 and +32767 this gives -75776 and 75774, with no overflow of the 18-bit output.
- R8: Internally, the low shared bus is exactly three quarters and the high shared bus exactly five quarters of the extended input. Odd input amplitudes therefore lose no bits before the final rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Qualifies inData in this cycle |
| inData | input | 16 | Input sample, two's complement |
| outValid | output | 1 | Marks a new filtered sample |
| outData | output | 18 | Filtered, rounded sample, two's complement |

## Verification
The bench builds the filter with its default parameters: 16-bit input, four fractional guard bits, an 18-bit output and the four taps 0.75, -0.3125, 0.625 and 1.25. With these values the tests can reach:

- impulses of very small magnitude, where round-half-up decides every output;
- full-scale steps at both extremes of the input range, which bring the output close to its range limits;
- every coefficient tap at least once, including the 0.75 tap on the low bus and the taps on the high bus with shifts of zero, one and two.

Randomly placed idle cycles carrying junk data then show that the chain and the output register hold their contents.

// File: rtl/fir_share_pkg.sv
package fir_share_pkg;

  // Bus selector for a tap term
  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_RAW  = 2'd1,
    BUS_LO   = 2'd2,   // x - x/4
    BUS_HI   = 2'd3    // x + x/4
  } bus_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic outLoad;
  } fir_ctrl_t;

  // Term encoding: [7:6] bus, [5] negate, [4:0] right shift
  function automatic logic [7:0] mkTerm(bus_sel_e bus, logic neg, int unsigned sh);
    logic [4:0] shBits;
    shBits = sh[4:0];
    return {bus, neg, shBits};
  endfunction

  // Tap 0 in the low byte: 0.75, -0.3125, 0.625, 1.25
  localparam logic [31:0] DEF_TERM_A = {
    mkTerm(BUS_HI, 1'b0, 0),
    mkTerm(BUS_HI, 1'b0, 1),
    mkTerm(BUS_HI, 1'b1, 2),
    mkTerm(BUS_LO, 1'b0, 0)
  };
  localparam logic [31:0] DEF_TERM_B = 32'd0;

endpackage

// File: rtl/fir_bus_gen.sv
module fir_bus_gen #(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 4,
  parameter int ACC_W  = 23
) (
  input  logic [IN_W-1:0]         inData,
  output logic signed [ACC_W-1:0] busRaw,
  output logic signed [ACC_W-1:0] busLo,
  output logic signed [ACC_W-1:0] busHi
);
  localparam int EXT_W = ACC_W - IN_W - FRAC_W;

  logic signed [ACC_W-1:0] quarter;

  always_comb begin
    busRaw  = {{EXT_W{inData[IN_W-1]}}, inData, {FRAC_W{1'b0}}};
    quarter = busRaw >>> 2;
    busLo   = busRaw - quarter;
    busHi   = busRaw + quarter;
  end
endmodule

// File: rtl/fir_tap_term.sv
module fir_tap_term #(
  parameter int         ACC_W = 23,
  parameter logic [7:0] TERM  = 8'h00
) (
  input  logic signed [ACC_W-1:0] busRaw,
  input  logic signed [ACC_W-1:0] busLo,
  input  logic signed [ACC_W-1:0] busHi,
  output logic signed [ACC_W-1:0] term
);
  localparam logic [1:0] SEL   = TERM[7:6];
  localparam logic       NEG   = TERM[5];
  localparam int         SHIFT = int'(TERM[4:0]);

  logic signed [ACC_W-1:0] src;
  logic signed [ACC_W-1:0] shifted;

  always_comb begin
    case (SEL)
      2'd1:    src = busRaw;
      2'd2:    src = busLo;
      2'd3:    src = busHi;
      default: src = '0;
    endcase
    shifted = src >>> SHIFT;
    term    = NEG ? -shifted : shifted;
  end
endmodule

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_share_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output fir_ctrl_t ctrl,
  output logic      outValid
);
  always_comb begin
    ctrl.shiftEn = inValid;
    ctrl.outLoad = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);                                   // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);                                 // R2
endmodule

// File: rtl/fir_datapath.sv
module fir_datapath
  import fir_share_pkg::*;
#(
  parameter int                      IN_W   = 16,
  parameter int                      FRAC_W = 4,
  parameter int                      OUT_W  = 18,
  parameter int                      NTAPS  = 4,
  parameter int                      ACC_W  = 23,
  parameter logic [NTAPS-1:0][7:0]   TERM_A = DEF_TERM_A,
  parameter logic [NTAPS-1:0][7:0]   TERM_B = DEF_TERM_B
) (
  input  logic             clk,
  input  logic             rstN,
  input  fir_ctrl_t        ctrl,
  input  logic [IN_W-1:0]  inData,
  output logic [OUT_W-1:0] outData
);
  localparam logic signed [ACC_W-1:0] RND = ACC_W'(1 << (FRAC_W - 1));

  logic signed [ACC_W-1:0] busRaw, busLo, busHi;
  logic signed [ACC_W-1:0] termA [NTAPS];
  logic signed [ACC_W-1:0] termB [NTAPS];
  logic signed [ACC_W-1:0] zReg  [NTAPS-1];
  logic signed [ACC_W-1:0] zNext [NTAPS-1];
  logic signed [ACC_W-1:0] sum0;
  logic signed [ACC_W-1:0] rounded;

  fir_bus_gen #(.IN_W(IN_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) uBus (
    .inData(inData), .busRaw(busRaw), .busLo(busLo), .busHi(busHi)
  );

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    fir_tap_term #(.ACC_W(ACC_W), .TERM(TERM_A[k])) uTermA (
      .busRaw(busRaw), .busLo(busLo), .busHi(busHi), .term(termA[k])
    );
    fir_tap_term #(.ACC_W(ACC_W), .TERM(TERM_B[k])) uTermB (
      .busRaw(busRaw), .busLo(busLo), .busHi(busHi), .term(termB[k])
    );
  end

  // Transposed chain: element k-1 stores tap k plus the element behind it
  for (genvar k = 1; k < NTAPS; k++) begin : g_chain
    if (k == NTAPS - 1) begin : g_tail
      assign zNext[k-1] = termA[k] + termB[k];
    end else begin : g_mid
      assign zNext[k-1] = termA[k] + termB[k] + zReg[k];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             zReg[k-1] <= '0;
      else if (ctrl.shiftEn) zReg[k-1] <= zNext[k-1];
    end
  end

  always_comb begin
    sum0    = termA[0] + termB[0] + zReg[0];
    rounded = (sum0 + RND) >>> FRAC_W;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outData <= '0;
    else if (ctrl.outLoad) outData <= rounded[OUT_W-1:0];
  end

  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.shiftEn |=> ($stable(zReg[0]) && $stable(zReg[NTAPS-2])));  // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.outLoad |=> $stable(outData));                               // R5
  AST_BUS_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    ((busLo <<< 2) == (busRaw + (busRaw <<< 1))) &&
    ((busHi <<< 2) == ((busRaw <<< 2) + busRaw)));                      // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.outLoad |-> ((rounded[ACC_W-1:OUT_W-1] == '0) ||
                      (rounded[ACC_W-1:OUT_W-1] == '1)));               // R7
endmodule

// File: rtl/fir_csd_share.sv
module fir_csd_share
  import fir_share_pkg::*;
#(
  parameter int                    IN_W   = 16,
  parameter int                    FRAC_W = 4,
  parameter int                    OUT_W  = 18,
  parameter int                    NTAPS  = 4,
  parameter logic [NTAPS-1:0][7:0] TERM_A = DEF_TERM_A,
  parameter logic [NTAPS-1:0][7:0] TERM_B = DEF_TERM_B
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  output logic             outValid,
  output logic [OUT_W-1:0] outData
);
  localparam int ACC_W = IN_W + FRAC_W + 3;

  fir_ctrl_t ctrl;

  fir_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctrl(ctrl), .outValid(outValid)
  );

  fir_datapath #(
    .IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .NTAPS(NTAPS),
    .ACC_W(ACC_W), .TERM_A(TERM_A), .TERM_B(TERM_B)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inData(inData), .outData(outData)
  );
endmodule

// File: tb/sim_fir_csd_share.sv
module sim_fir_csd_share;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inData = 16'd0;
  logic        outValid;
  logic [17:0] outData;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  typedef struct {
    int    val;
    string tag;
  } item_t;
  item_t sbQ[$];

  int hist [4] = '{0, 0, 0, 0};
  logic expValid = 1'b0;
  int lastOut = 0;

  always #5 clk = ~clk;

  fir_csd_share u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model independent of the RTL structure
  function automatic int model();
    int s;
    s = 12 * hist[0] - 5 * hist[1] + 10 * hist[2] + 20 * hist[3] + 8;
    return s >>> 4;
  endfunction

  task automatic sendSample(input int v, input bit vld, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    inData  = 16'(v);
    inValid = vld;
    if (vld) begin
      hist[3] = hist[2];
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = v;
      it.val = model();
      it.tag = tag;
      sbQ.push_back(it);
    end
  endtask

  task automatic impulse(input int a, input string tag);
    sendSample(a, 1'b1, tag);
    for (int i = 0; i < 5; i++) sendSample(0, 1'b1, tag);
  endtask

  // Expected-valid flop sampled before the driver moves its inputs
  always @(posedge clk or negedge rstN) begin
    if (!rstN) expValid <= 1'b0;
    else       expValid <= inValid;
  end

  // Monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rstN && !finished) begin
      int act;
      act = int'($signed(outData));
      check(outValid == expValid, "R2 outValid timing", int'(outValid), int'(expValid));
      if (outValid) begin
        if (sbQ.size() == 0) begin
          check(1'b0, "R2 output with empty scoreboard", act, 0);
        end else begin
          item_t it;
          it = sbQ.pop_front();
          check(act == it.val, it.tag, act, it.val);
        end
        lastOut = act;
      end else begin
        check(act == lastOut, "R5 outData held while idle", act, lastOut);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failCount++;
      checkCount++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R1 reset outValid", int'(outValid), 0);
    check(outData == 18'd0, "R1 reset outData", int'($signed(outData)), 0);
    #1 rstN = 1'b1;
    repeat (2) @(posedge clk);

    // R1: first output right after reset is only 0.75 of the first sample
    impulse(1000, "R1 first sample after reset");
    // R3: impulse response follows the coefficient order
    impulse(-2048, "R3 impulse response");
    // R6: round-half-up on tiny impulses
    impulse(1, "R6 rounding +1");
    impulse(-1, "R6 rounding -1");
    impulse(8, "R6 rounding half");
    // R8: odd amplitudes exercise exactness of the shared buses
    impulse(-32767, "R8 exact buses odd amplitude");
    impulse(12345, "R8 exact buses odd amplitude");

    // R7: step response and full scale
    for (int i = 0; i < 8; i++) sendSample(4000, 1'b1, "R7 step 4000");
    for (int i = 0; i < 8; i++) sendSample(-32768, 1'b1, "R7 full scale negative");
    for (int i = 0; i < 8; i++) sendSample(32767, 1'b1, "R7 full scale positive");

    // R5: idle cycles with junk data between valid samples
    for (int i = 0; i < 40; i++) begin
      sendSample(int'($urandom_range(0, 65535)) - 32768, 1'b1, "R5 sample around bubbles");
      sendSample(int'($urandom_range(0, 65535)), 1'b0, "R5");
      sendSample(int'($urandom_range(0, 65535)), 1'b0, "R5");
    end

    // R4: random data with random gaps
    for (int i = 0; i < 400; i++) begin
      bit vld;
      vld = ($urandom_range(0, 3) != 0);
      sendSample(int'($urandom_range(0, 65535)) - 32768, vld, "R4 random convolution");
    end

    for (int i = 0; i < 4; i++) sendSample(0, 1'b0, "R2");
    @(negedge clk);
    check(sbQ.size() == 0, "R2 every accepted sample produced one output", sbQ.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule